// File: doc/BRIEF.md
# Register-to-Register ALU Operation Unit

This block runs the arithmetic and logic instructions whose two operands both live in the processor's register file. An instruction sequencer hands it a three-bit operation code and a post-byte. The post-byte uses the same register numbering as the register-transfer instruction. The upper nibble names the first operand (R0) and the lower nibble names the second operand (R1). The block reads both operands through two read ports, computes `R1 op R0`, and writes the result back into R1 through a single write port. It also reports a new set of N, Z, V and C flags for the condition-code register.

Every accepted instruction takes exactly three cycles: a read cycle, a compute cycle and a write-back cycle. Pairs of 8-bit registers produce an 8-bit operation. A pair that mixes widths is promoted to a 16-bit operation. The zero register reads as zero whatever the register file returns, and writes to it are dropped. The program counter can be a source or a destination. A write to it goes out like any other write, and the register file then redirects execution.

Top module: `alu_rr_unit`

## Requirements
- R1: A `start` seen while `busy` is low is accepted. `busy` is high for the next three cycles, and `done` is high only in the third of them, which is also the cycle in which the write and the flag update appear. A `start` seen while `busy` is high has no effect.
- R2: Register codes are: 0 D, 1 X, 2 Y, 3 U, 4 S, 5 PC, 6 W, 7 V, 8 A, 9 B, 10 CC, 11 DP, 12 and 13 the zero register, 14 E, 15 F. During the read cycle, `src_addr` carries the R0 code from post-byte bits [7:4] and `dst_addr` carries the R1 code from bits [3:0], both after promotion.
- R3: Operation code 0 (add) and 1 (add with carry, using `cc_in` bit 0) produce R1+R0(+C). C is the carry out of the operand's top bit, and V is two's-complement overflow.
- R4: Operation code 2 (subtract) and 3 (subtract with borrow) produce R1−R0(−C). C is set when a borrow occurs, and V is two's-complement overflow.
- R5: Operation code 4 (compare) sets flags exactly as subtract does and writes no register.
- R6: Operation code 5 (exclusive-or) and 6 (or) clear V and pass `cc_in` bit 0 through unchanged as C.
- R7: The flag bus is ordered {N,Z,V,C} (bit 3 down to 0). N is the result's top bit and Z marks an all-zero result. When both codes are 8-bit (8 to 15), the operation is 8 bits wide and the upper byte of `wr_data` is zero. Otherwise A and B are promoted to D, E and F are promoted to W, and the operation is 16 bits wide.
- R8: A zero-register operand reads as zero regardless of the read data. With the zero register as destination, no write is issued, but the flags are still updated.
- R9: The PC is read like any other register when named as R0, and a result destined for it is written at code 5.
- R10: A 16-bit register paired with CC or DP completes in the normal three cycles without fault. The value produced is unspecified.
- R11: Operation code 7 completes with `done`, but issues neither a register write nor a flag update.
- R12: After a synchronous active-low reset, `busy`, `done`, `wr_en` and `flags_we` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an instruction |
| opcode | input | 3 | Operation select |
| post_byte | input | 8 | R0 code in [7:4], R1 code in [3:0] |
| cc_in | input | 4 | Current {N,Z,V,C} |
| src_addr | output | 4 | Read address for R0 |
| dst_addr | output | 4 | Read address for R1 |
| src_data | input | 16 | Read data for R0 (8-bit registers in low byte) |
| dst_data | input | 16 | Read data for R1 |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 4 | Register write code |
| wr_data | output | 16 | Register write value |
| flags_we | output | 1 | Flag update strobe |
| flags_out | output | 4 | New {N,Z,V,C} |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Final cycle of an instruction |

## Verification
The add and subtract paths are driven with operands that sit on the signed and unsigned limits, so that a carry out, a borrow and a signed overflow each appear alone and in combination. The carry-in of the with-carry variants is tried both set and clear, and the logic operations are run with C preset both ways, to show that C is held and not recomputed. The register pairs cover byte-with-byte, byte-with-word (A into D, F into W), the zero register on each side, and the PC on each side. Together these separate a wrong promotion, a missing write suppression and a wrong operand order. A reserved operation code, a CC/word pairing and a second `start` issued while busy complete the set.

// File: rtl/alu_rr_pkg.sv
// Shared types for the register-to-register ALU unit.
// Assumes the register numbering shared with the transfer instruction.
package alu_rr_pkg;
    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBC = 3'd3,
        OP_CMP = 3'd4,
        OP_EOR = 3'd5,
        OP_OR  = 3'd6,
        OP_NOP = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_EXEC = 2'd2,
        ST_WB   = 2'd3
    } seq_state_e;

    localparam logic [3:0] RC_D    = 4'h0;
    localparam logic [3:0] RC_W    = 4'h6;
    localparam logic [3:0] RC_A    = 4'h8;
    localparam logic [3:0] RC_B    = 4'h9;
    localparam logic [3:0] RC_ZLO  = 4'hC;
    localparam logic [3:0] RC_ZHI  = 4'hD;
    localparam logic [3:0] RC_E    = 4'hE;
    localparam logic [3:0] RC_F    = 4'hF;
endpackage

// File: rtl/alu_rr_decode.sv
// Post-byte decoder: splits the post-byte into the R0/R1 codes, decides
// the operation width, promotes byte names to their word pair when the
// widths differ, and flags zero-register codes.
// Assumes a code with its top bit clear names a 16-bit register.
module alu_rr_decode
    import alu_rr_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic [2*CW-1:0] post_byte,
    output logic [CW-1:0]   src_code,
    output logic [CW-1:0]   dst_code,
    output logic            wide,
    output logic            src_zero,
    output logic            dst_zero
);
    logic [CW-1:0] raw_src;
    logic [CW-1:0] raw_dst;

    // Map a byte accumulator name onto its 16-bit pair.
    function automatic logic [CW-1:0] promote(input logic [CW-1:0] code);
        logic [CW-1:0] r;
        r = code;
        if (code == RC_A || code == RC_B) r = RC_D;
        if (code == RC_E || code == RC_F) r = RC_W;
        return r;
    endfunction

    // True for either of the two zero-register codes.
    function automatic logic is_zero(input logic [CW-1:0] code);
        return (code == RC_ZLO) || (code == RC_ZHI);
    endfunction

    // Split, width-decide, promote and classify.
    always_comb begin
        raw_src  = post_byte[2*CW-1:CW];
        raw_dst  = post_byte[CW-1:0];
        wide     = !raw_src[CW-1] || !raw_dst[CW-1];
        src_code = wide ? promote(raw_src) : raw_src;
        dst_code = wide ? promote(raw_dst) : raw_dst;
        src_zero = is_zero(raw_src);
        dst_zero = is_zero(raw_dst);
    end
endmodule

// File: rtl/alu_rr_core.sv
// Combinational datapath of width W: computes b OP a (b is R1, a is R0)
// and the N, Z, V, C flags. Assumes cin is the current C flag.
module alu_rr_core
    import alu_rr_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           cin,
    output logic [W-1:0]   res,
    output flags_t         fl
);
    localparam int MSB = W - 1;

    logic [W:0] ext;
    logic       ci;

    // Arithmetic/logic result and flag generation.
    always_comb begin
        ci   = ((op == OP_ADC) || (op == OP_SBC)) ? cin : 1'b0;
        ext  = '0;
        res  = b;
        fl.v = 1'b0;
        fl.c = cin;
        case (op)
            OP_ADD, OP_ADC: begin
                ext  = {1'b0, b} + {1'b0, a} + {{W{1'b0}}, ci};
                res  = ext[W-1:0];
                fl.c = ext[W];
                fl.v = (a[MSB] == b[MSB]) && (res[MSB] != b[MSB]);
            end
            OP_SUB, OP_SBC, OP_CMP: begin
                ext  = {1'b0, b} - {1'b0, a} - {{W{1'b0}}, ci};
                res  = ext[W-1:0];
                fl.c = ext[W];
                fl.v = (a[MSB] != b[MSB]) && (res[MSB] != b[MSB]);
            end
            OP_EOR: res = b ^ a;
            OP_OR:  res = b | a;
            default: res = b;
        endcase
        fl.n = res[MSB];
        fl.z = (res == '0);
    end
endmodule

// File: rtl/alu_rr_unit.sv
// Register-to-register ALU unit: a three-cycle sequencer (read, compute,
// write back) around a post-byte decoder and two datapath widths.
// Assumes the register file returns read data combinationally for the
// addresses driven in the read cycle, with byte registers in the low byte.
module alu_rr_unit
    import alu_rr_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 4,
    parameter int FW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [2:0]      opcode,
    input  logic [2*CW-1:0] post_byte,
    input  logic [FW-1:0]   cc_in,
    output logic [CW-1:0]   src_addr,
    output logic [CW-1:0]   dst_addr,
    input  logic [DW-1:0]   src_data,
    input  logic [DW-1:0]   dst_data,
    output logic            wr_en,
    output logic [CW-1:0]   wr_addr,
    output logic [DW-1:0]   wr_data,
    output logic            flags_we,
    output logic [FW-1:0]   flags_out,
    output logic            busy,
    output logic            done
);
    localparam int HW = DW / 2;

    seq_state_e     state;
    alu_op_e        op_q;
    logic [2*CW-1:0] pb_q;
    logic [DW-1:0]  a_q;
    logic [DW-1:0]  b_q;
    logic           cin_q;
    logic [DW-1:0]  res_q;
    flags_t         fl_q;

    logic [CW-1:0]  src_code;
    logic [CW-1:0]  dst_code;
    logic           wide;
    logic           src_zero;
    logic           dst_zero;

    logic [DW-1:0]  res_w;
    logic [HW-1:0]  res_h;
    flags_t         fl_w;
    flags_t         fl_h;
    logic           op_writes;

    alu_rr_decode #(.CW(CW)) dec_i (
        .post_byte (pb_q),
        .src_code  (src_code),
        .dst_code  (dst_code),
        .wide      (wide),
        .src_zero  (src_zero),
        .dst_zero  (dst_zero)
    );

    alu_rr_core #(.W(DW)) core_w_i (
        .op  (op_q),
        .a   (a_q),
        .b   (b_q),
        .cin (cin_q),
        .res (res_w),
        .fl  (fl_w)
    );

    alu_rr_core #(.W(HW)) core_h_i (
        .op  (op_q),
        .a   (a_q[HW-1:0]),
        .b   (b_q[HW-1:0]),
        .cin (cin_q),
        .res (res_h),
        .fl  (fl_h)
    );

    // Sequencer: accept, capture operands, capture result, write back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            op_q  <= OP_NOP;
            pb_q  <= '0;
            a_q   <= '0;
            b_q   <= '0;
            cin_q <= 1'b0;
            res_q <= '0;
            fl_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    op_q  <= alu_op_e'(opcode);
                    pb_q  <= post_byte;
                    state <= ST_READ;
                end
                ST_READ: begin
                    a_q   <= src_zero ? '0 : src_data;
                    b_q   <= dst_zero ? '0 : dst_data;
                    cin_q <= cc_in[0];
                    state <= ST_EXEC;
                end
                ST_EXEC: begin
                    res_q <= wide ? res_w : {{(DW-HW){1'b0}}, res_h};
                    fl_q  <= wide ? fl_w : fl_h;
                    state <= ST_WB;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Operations that store a result (compare and reserved do not).
    always_comb begin
        op_writes = (op_q != OP_CMP) && (op_q != OP_NOP);
    end

    // Port drive from sequencer state.
    always_comb begin
        src_addr  = src_code;
        dst_addr  = dst_code;
        busy      = (state != ST_IDLE);
        done      = (state == ST_WB);
        wr_en     = (state == ST_WB) && op_writes && !dst_zero;
        wr_addr   = dst_code;
        wr_data   = res_q;
        flags_we  = (state == ST_WB) && (op_q != OP_NOP);
        flags_out = fl_q;
    end

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |-> ##3 done); // R1
    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (op_q != OP_CMP)); // R5
    AST_LOGIC_V_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_we && (op_q == OP_EOR || op_q == OP_OR)) |-> !flags_out[1]); // R6
    AST_WIDE_NO_BYTE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wide) |-> (wr_addr != RC_A && wr_addr != RC_B &&
                             wr_addr != RC_E && wr_addr != RC_F)); // R7
    AST_ZERO_DEST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr != RC_ZLO && wr_addr != RC_ZHI)); // R8
    AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_NOP) |-> (!flags_we && !wr_en)); // R11
endmodule

// File: tb/alu_rr_unit_tb.sv
// Directed bench for alu_rr_unit with a behavioural register file.
module alu_rr_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  opcode = 3'd0;
    logic [7:0]  post_byte = 8'h00;
    logic [3:0]  cc_in;
    logic [3:0]  src_addr, dst_addr;
    logic [15:0] src_data, dst_data;
    logic        wr_en, flags_we, busy, done;
    logic [3:0]  wr_addr, flags_out;
    logic [15:0] wr_data;

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0]  ra, rb, re, rf, rcc, rdp;
    logic [15:0] rx, ry, ru, rs, rpc, rv;
    logic [3:0]  flags;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_rr_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .post_byte(post_byte), .cc_in(cc_in), .src_addr(src_addr),
        .dst_addr(dst_addr), .src_data(src_data), .dst_data(dst_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .flags_we(flags_we), .flags_out(flags_out), .busy(busy), .done(done)
    );

    function automatic logic [15:0] rd(input logic [3:0] c);
        case (c)
            4'h0: return {ra, rb};
            4'h1: return rx;
            4'h2: return ry;
            4'h3: return ru;
            4'h4: return rs;
            4'h5: return rpc;
            4'h6: return {re, rf};
            4'h7: return rv;
            4'h8: return {8'h00, ra};
            4'h9: return {8'h00, rb};
            4'hA: return {8'h00, rcc};
            4'hB: return {8'h00, rdp};
            4'hE: return {8'h00, re};
            4'hF: return {8'h00, rf};
            default: return 16'hDEAD;
        endcase
    endfunction

    assign src_data = rd(src_addr);
    assign dst_data = rd(dst_addr);
    assign cc_in    = flags;

    always @(posedge clk) begin
        if (wr_en) begin
            case (wr_addr)
                4'h0: begin ra <= wr_data[15:8]; rb <= wr_data[7:0]; end
                4'h1: rx <= wr_data;
                4'h2: ry <= wr_data;
                4'h3: ru <= wr_data;
                4'h4: rs <= wr_data;
                4'h5: rpc <= wr_data;
                4'h6: begin re <= wr_data[15:8]; rf <= wr_data[7:0]; end
                4'h7: rv <= wr_data;
                4'h8: ra <= wr_data[7:0];
                4'h9: rb <= wr_data[7:0];
                4'hA: rcc <= wr_data[7:0];
                4'hB: rdp <= wr_data[7:0];
                4'hE: re <= wr_data[7:0];
                4'hF: rf <= wr_data[7:0];
                default: ;
            endcase
        end
        if (flags_we) flags <= flags_out;
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [3:0] promo(input logic [3:0] c, input bit w);
        if (w && (c == 4'h8 || c == 4'h9)) return 4'h0;
        if (w && (c == 4'hE || c == 4'hF)) return 4'h6;
        return c;
    endfunction

    // Reference model built from the requirement text.
    task automatic predict(input logic [2:0] op, input logic [7:0] pb,
                           output bit e_we, output logic [3:0] e_addr,
                           output logic [15:0] e_data, output bit e_fwe,
                           output logic [3:0] e_fl, output logic [3:0] e_s,
                           output logic [3:0] e_d);
        bit w = !pb[7] || !pb[3];
        int wd = w ? 16 : 8;
        int mx = (1 << wd) - 1;
        int hf = 1 << (wd - 1);
        bit z0 = (pb[7:4] == 4'hC) || (pb[7:4] == 4'hD);
        bit z1 = (pb[3:0] == 4'hC) || (pb[3:0] == 4'hD);
        int a, b, ci, s, sa, sb, ss, res;
        bit v, c;
        e_s = promo(pb[7:4], w);
        e_d = promo(pb[3:0], w);
        a = z0 ? 0 : (int'(rd(e_s)) & mx);
        b = z1 ? 0 : (int'(rd(e_d)) & mx);
        sa = (a >= hf) ? a - (mx + 1) : a;
        sb = (b >= hf) ? b - (mx + 1) : b;
        ci = (op == 3'd1 || op == 3'd3) ? int'(flags[0]) : 0;
        v = 1'b0; c = flags[0]; res = b;
        case (op)
            3'd0, 3'd1: begin
                s = b + a + ci; c = (s > mx); ss = sb + sa + ci;
                v = (ss > hf - 1) || (ss < -hf); res = s & mx;
            end
            3'd2, 3'd3, 3'd4: begin
                s = b - a - ci; c = (s < 0); ss = sb - sa - ci;
                v = (ss > hf - 1) || (ss < -hf); res = s & mx;
            end
            3'd5: res = b ^ a;
            3'd6: res = b | a;
            default: ;
        endcase
        e_fl   = {res >= hf, res == 0, v, c};
        e_data = 16'(res);
        e_addr = e_d;
        e_we   = (op != 3'd4) && (op != 3'd7) && !z1;
        e_fwe  = (op != 3'd7);
    endtask

    // Run one instruction and check timing, addresses, write and flags.
    task automatic run_op(input logic [2:0] op, input logic [7:0] pb,
                          input string tag, input bit values);
        bit e_we, e_fwe;
        logic [3:0] e_addr, e_fl, e_s, e_d;
        logic [15:0] e_data;
        predict(op, pb, e_we, e_addr, e_data, e_fwe, e_fl, e_s, e_d);
        @(negedge clk); start = 1'b1; opcode = op; post_byte = pb;
        @(negedge clk); start = 1'b0;
        chk(busy && !done, tag, "read-cycle busy/done", {busy, done}, 2'b10);
        if (values) begin
            chk(src_addr == e_s, "R2", "src_addr", src_addr, e_s);
            chk(dst_addr == e_d, "R2", "dst_addr", dst_addr, e_d);
        end
        @(negedge clk);
        chk(busy && !done, "R1", "compute-cycle busy/done", {busy, done}, 2'b10);
        @(negedge clk);
        chk(done && busy, "R1", "done in third cycle", {busy, done}, 2'b11);
        if (values) begin
            chk(wr_en == e_we, tag, "wr_en", wr_en, e_we);
            if (e_we) begin
                chk(wr_addr == e_addr, tag, "wr_addr", wr_addr, e_addr);
                chk(wr_data == e_data, tag, "wr_data", wr_data, e_data);
            end
            chk(flags_we == e_fwe, tag, "flags_we", flags_we, e_fwe);
            if (e_fwe) chk(flags_out == e_fl, tag, "flags", flags_out, e_fl);
        end
        @(negedge clk);
        chk(!busy && !done, "R1", "idle after write-back", {busy, done}, 2'b00);
    endtask

    task automatic t_reset();
        chk(!busy && !done && !wr_en && !flags_we, "R12", "reset outputs",
            {busy, done, wr_en, flags_we}, 0);
    endtask

    task automatic t_add();
        ra = 8'h7F; rb = 8'h01; flags = 4'h0;
        run_op(3'd0, 8'h89, "R3", 1'b1);        // 8-bit overflow to 0x80
        chk(rb == 8'h80, "R3", "B after add", rb, 8'h80);
        rx = 16'hFFFF; ry = 16'h0001; flags = 4'h1;
        run_op(3'd1, 8'h12, "R3", 1'b1);        // add with carry, wraps
        chk(ry == 16'h0001 && flags == 4'h1, "R3", "Y/flags after adc",
            {ry, flags}, {16'h0001, 4'h1});
    endtask

    task automatic t_sub();
        re = 8'h10; rf = 8'h20; flags = 4'h0;
        run_op(3'd2, 8'hFE, "R4", 1'b1);        // borrow, result 0xF0
        chk(re == 8'hF0 && flags == 4'h9, "R4", "E/flags after sub",
            {re, flags}, {8'hF0, 4'h9});
        ru = 16'h8000; rs = 16'h0001; flags = 4'h1;
        run_op(3'd3, 8'h43, "R4", 1'b1);        // signed overflow, 0x7FFE
        chk(ru == 16'h7FFE, "R4", "U after sbc", ru, 16'h7FFE);
    endtask

    task automatic t_cmp();
        rx = 16'h1234; ry = 16'h1234; flags = 4'h0;
        run_op(3'd4, 8'h12, "R5", 1'b1);
        chk(ry == 16'h1234 && flags[2], "R5", "Y kept, Z set",
            {ry, flags}, {16'h1234, 4'h4});
    endtask

    task automatic t_logic();
        ra = 8'hF0; rb = 8'hFF; flags = 4'h3;
        run_op(3'd5, 8'h89, "R6", 1'b1);        // C held at 1, V cleared
        chk(flags == 4'h1 && rb == 8'h0F, "R6", "eor B/flags",
            {rb, flags}, {8'h0F, 4'h1});
        flags = 4'h0;
        run_op(3'd6, 8'h98, "R6", 1'b1);
    endtask

    task automatic t_mixed();
        ra = 8'h01; rb = 8'h02; rx = 16'h1000; flags = 4'h0;
        run_op(3'd0, 8'h81, "R7", 1'b1);        // A promoted to D
        chk(rx == 16'h1102, "R7", "X after D+X", rx, 16'h1102);
        re = 8'h00; rf = 8'h80;
        run_op(3'd0, 8'h1F, "R7", 1'b1);        // F promoted to W
        chk({re, rf} == 16'h1182, "R7", "W after X+W", {re, rf}, 16'h1182);
    endtask

    task automatic t_zero();
        rx = 16'h4321; flags = 4'h0;
        run_op(3'd0, 8'hC1, "R8", 1'b1);        // zero source ignores 0xDEAD
        chk(rx == 16'h4321, "R8", "X plus zero", rx, 16'h4321);
        run_op(3'd2, 8'h1D, "R8", 1'b1);        // zero dest: flags only
        chk(flags == 4'h9, "R8", "flags from 0-X", flags, 4'h9);
    endtask

    task automatic t_pc();
        rx = 16'h0010; rpc = 16'h2000; flags = 4'h0;
        run_op(3'd0, 8'h15, "R9", 1'b1);
        chk(rpc == 16'h2010, "R9", "PC after add", rpc, 16'h2010);
        run_op(3'd6, 8'h51, "R9", 1'b1);
        chk(rx == 16'h2010, "R9", "X or PC", rx, 16'h2010);
    endtask

    task automatic t_ccmix();
        rcc = 8'h55; rx = 16'h0101;
        run_op(3'd0, 8'h1A, "R10", 1'b0);
    endtask

    task automatic t_reserved();
        rx = 16'h0001; ry = 16'h0002; flags = 4'h5;
        run_op(3'd7, 8'h12, "R11", 1'b1);
        chk(ry == 16'h0002 && flags == 4'h5, "R11", "Y/flags untouched",
            {ry, flags}, {16'h0002, 4'h5});
    endtask

    task automatic t_busy_start();
        ra = 8'h03; rb = 8'h04; ru = 16'h7777; flags = 4'h0;
        @(negedge clk); start = 1'b1; opcode = 3'd0; post_byte = 8'h89;
        @(negedge clk); opcode = 3'd6; post_byte = 8'h13;
        @(negedge clk);
        chk(!done, "R1", "no early done", done, 0);
        @(negedge clk);
        chk(done && wr_addr == 4'h9 && wr_data == 16'h0007, "R1",
            "first instruction wins", wr_data, 16'h0007);
        start = 1'b0;
        @(negedge clk);
        chk(!busy && ru == 16'h7777, "R1", "second start ignored",
            {busy, ru}, {1'b0, 16'h7777});
    endtask

    initial begin
        ra = 0; rb = 0; re = 0; rf = 0; rcc = 0; rdp = 0;
        rx = 0; ry = 0; ru = 0; rs = 0; rpc = 0; rv = 0; flags = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_add();
        t_sub();
        t_cmp();
        t_logic();
        t_mixed();
        t_zero();
        t_pc();
        t_ccmix();
        t_reserved();
        t_busy_start();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule